// File: doc/BRIEF.md
# Serial mouse packet encoder

This block turns pointer motion and button state into the five-byte packet a serial mouse sends. Each time the event strobe is accepted, the block captures the X and Y deltas and the three button flags. It builds a header byte, a saturated X byte, a saturated and negated Y byte and two trailing zero bytes. It then writes those bytes, one per clock, into an internal byte queue.

A host drains the queue one byte at a time. The read port always shows the byte at the head of the queue. A flag stays high while at least one byte is waiting. A one-cycle pulse on `rd_en` removes the head byte. A one-cycle pulse on `clr` empties the queue. The timing of the serial line and the host register interface are handled elsewhere.

Top module: `mouse_pkt_enc`

## Requirements
- R1: The first byte of a packet is 0x87 with bit 2 cleared when left is pressed, bit 1 cleared when middle is pressed and bit 0 cleared when right is pressed (all pressed gives 0x80).
- R2: The second byte is `evt_dx` clamped to -127..+127 and written as 8-bit two's complement, so any value below -127 gives 0x81 and any value above +127 gives 0x7F.
- R3: The third byte is the negation of `evt_dy`, clamped to -127..+127 in the same way.
- R4: The fourth and fifth bytes are 0x00, and the bytes of a packet leave the queue in the order header, X, Y, zero, zero.
- R5: A strobe accepted at clock edge T queues its five bytes at edges T+1 through T+5. Any strobe seen at edges T+1 through T+5 is ignored.
- R6: The queue holds QDEPTH bytes (default 256). A byte offered while the queue is full is dropped, and the bytes already stored are kept.
- R7: While the queue is empty, `rd_data` is 0x00. A read pulse on an empty queue changes nothing.
- R8: `rd_avail` is high exactly when the queue holds at least one byte. It stays high after a read if bytes remain.
- R9: A one-cycle `clr` pulse empties the queue by the next cycle, and the queue then works normally.
- R10: After reset the queue is empty, `rd_avail` is low and `rd_data` is 0x00.
- R11: Bytes leave in the order they were stored, including after the read and write positions wrap past the end of storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | One-cycle queue clear |
| evt_valid | input | 1 | Event strobe |
| evt_dx | input | DELTA_W | Signed X motion |
| evt_dy | input | DELTA_W | Signed Y motion |
| btn_left | input | 1 | Left button pressed |
| btn_mid | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| rd_en | input | 1 | Remove the head byte |
| rd_data | output | 8 | Head byte, 0x00 when empty |
| rd_avail | output | 1 | Queue not empty |

## Verification
The bench uses the default parameters: DELTA_W = 10 and QDEPTH = 256. The 10-bit deltas span -512..+511, so both clamp limits are exercised, along with -128 and the most negative Y value, whose negation needs the extra bit. With the full 256-entry queue, the bench can fill the queue past capacity after the pointers have moved away from zero. This covers dropped bytes and index wrap-around in the same run.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned PKT_LEN = 5;
   localparam int          SAT_LIM = 127;
   localparam logic [BYTE_W-1:0] HDR_IDLE = 8'h87;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef struct packed {
      logic left;
      logic mid;
      logic right;
   } btn_t;
endpackage

// File: rtl/mpe_sat.sv
module mpe_sat
   import mpe_pkg::*;
#(
   parameter int unsigned IN_W   = 10,
   parameter bit          NEGATE = 1'b0
) (
   input  logic signed [IN_W-1:0] din,
   output byte_t                  dout
);
   localparam int unsigned EW = IN_W + 1;
   localparam logic signed [EW-1:0] POS_LIM = EW'(SAT_LIM);
   localparam logic signed [EW-1:0] NEG_LIM = -POS_LIM;

   logic signed [EW-1:0] ext;

   generate
      if (IN_W < BYTE_W) begin : g_bad_width
         $error("mpe_sat: IN_W must be at least one byte wide");
      end
      if (NEGATE) begin : g_negate
         assign ext = -($signed({din[IN_W-1], din}));
      end else begin : g_pass
         assign ext = $signed({din[IN_W-1], din});
      end
   endgenerate

   always_comb begin
      if (ext > POS_LIM)
         dout = POS_LIM[BYTE_W-1:0];
      else if (ext < NEG_LIM)
         dout = NEG_LIM[BYTE_W-1:0];
      else
         dout = ext[BYTE_W-1:0];
   end
endmodule

// File: rtl/mpe_packer.sv
module mpe_packer
   import mpe_pkg::*;
#(
   parameter int unsigned DELTA_W = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     evt_valid,
   input  logic signed [DELTA_W-1:0] dx,
   input  logic signed [DELTA_W-1:0] dy,
   input  btn_t                     btn,
   output logic                     push,
   output byte_t                    push_data
);
   localparam int unsigned IW = $clog2(PKT_LEN);

   byte_t         x_sat, y_sat, hdr;
   byte_t         pkt_q [PKT_LEN];
   logic [IW-1:0] idx_q;
   logic          busy_q;
   logic          accept;

   mpe_sat #(.IN_W(DELTA_W), .NEGATE(1'b0)) u_sat_x (.din(dx), .dout(x_sat));
   mpe_sat #(.IN_W(DELTA_W), .NEGATE(1'b1)) u_sat_y (.din(dy), .dout(y_sat));

   assign hdr    = HDR_IDLE & ~{5'b0, btn.left, btn.mid, btn.right};
   assign accept = evt_valid && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         for (int i = 0; i < int'(PKT_LEN); i++) pkt_q[i] <= '0;
      end else if (accept) begin
         pkt_q[0] <= hdr;
         pkt_q[1] <= x_sat;
         pkt_q[2] <= y_sat;
         for (int i = 3; i < int'(PKT_LEN); i++) pkt_q[i] <= '0;
         idx_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (idx_q == IW'(PKT_LEN - 1)) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign push      = busy_q;
   assign push_data = pkt_q[idx_q];
endmodule

// File: rtl/mpe_queue.sv
module mpe_queue
   import mpe_pkg::*;
#(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  byte_t         din,
   input  logic          pop,
   output byte_t         dout,
   output logic          avail,
   output logic [CW-1:0] count
);
   byte_t         mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic          wr_ok, rd_ok;

   generate
      if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
         $error("mpe_queue: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   assign wr_ok = push && (cnt != CW'(DEPTH));
   assign rd_ok = pop && (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (clr) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (wr_ok) wptr <= wptr + 1'b1;
         if (rd_ok) rptr <= rptr + 1'b1;
         cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok && !clr) mem[wptr] <= din;
   end

   assign avail = (cnt != '0);
   assign dout  = avail ? mem[rptr] : '0;
   assign count = cnt;
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
   import mpe_pkg::*;
#(
   parameter int unsigned DELTA_W = 10,
   parameter int unsigned QDEPTH  = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               evt_valid,
   input  logic [DELTA_W-1:0] evt_dx,
   input  logic [DELTA_W-1:0] evt_dy,
   input  logic               btn_left,
   input  logic               btn_mid,
   input  logic               btn_right,
   input  logic               rd_en,
   output logic [7:0]         rd_data,
   output logic               rd_avail
);
   localparam int unsigned CW = $clog2(QDEPTH) + 1;

   btn_t          btn;
   logic          pk_push;
   byte_t         pk_data;
   logic [CW-1:0] q_count;

   assign btn = '{left: btn_left, mid: btn_mid, right: btn_right};

   mpe_packer #(.DELTA_W(DELTA_W)) u_packer (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_valid (evt_valid),
      .dx        ($signed(evt_dx)),
      .dy        ($signed(evt_dy)),
      .btn       (btn),
      .push      (pk_push),
      .push_data (pk_data)
   );

   mpe_queue #(.DEPTH(QDEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (pk_push),
      .din   (pk_data),
      .pop   (rd_en),
      .dout  (rd_data),
      .avail (rd_avail),
      .count (q_count)
   );
endmodule

// File: rtl/mpe_chk.sv
module mpe_chk #(
   parameter int unsigned QDEPTH = 256,
   localparam int unsigned CW    = $clog2(QDEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clr,
   input logic          rd_en,
   input logic [7:0]    rd_data,
   input logic          rd_avail,
   input logic          pk_push,
   input logic [CW-1:0] q_count
);
   logic [3:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= '0;
      else        run <= pk_push ? run + 1'b1 : '0;
   end

   p_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pk_push |-> run < 4'd5);

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(QDEPTH));

   p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_avail |-> rd_data == 8'h00);

   p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_avail && rd_en && !pk_push && !clr) |=> !rd_avail);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_avail && !rd_en && !clr) |=> rd_avail);

   p_read_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_avail && rd_en && !pk_push && !clr) |=> q_count == $past(q_count) - 1'b1);

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !rd_avail);
endmodule

bind mouse_pkt_enc mpe_chk #(.QDEPTH(QDEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .rd_en    (rd_en),
   .rd_data  (rd_data),
   .rd_avail (rd_avail),
   .pk_push  (pk_push),
   .q_count  (q_count)
);

// File: tb/tb_mouse_pkt_enc.sv
`timescale 1ns/1ps
module tb_mouse_pkt_enc;
   localparam int DW = 10;
   localparam int QD = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic          evt_valid = 1'b0;
   logic [DW-1:0] evt_dx = '0, evt_dy = '0;
   logic          btn_left = 1'b0, btn_mid = 1'b0, btn_right = 1'b0;
   logic          rd_en = 1'b0;
   logic [7:0]    rd_data;
   logic          rd_avail;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic [7:0] mq [QD];
   int mh = 0, mt = 0, mc = 0;

   always #2.5 clk = ~clk;

   mouse_pkt_enc #(.DELTA_W(DW), .QDEPTH(QD)) dut (.*);

   function automatic logic [7:0] sat8(int v);
      if (v > 127)  return 8'h7F;
      if (v < -127) return 8'h81;
      return 8'(v);
   endfunction

   function automatic logic [7:0] hdr(bit l, bit m, bit r);
      logic [7:0] h = 8'h87;
      if (l) h[2] = 1'b0;
      if (m) h[1] = 1'b0;
      if (r) h[0] = 1'b0;
      return h;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic mpush(logic [7:0] b);
      if (mc < QD) begin
         mq[mt] = b;
         mt = (mt + 1) % QD;
         mc++;
      end
   endtask

   task automatic model_pkt(int dx, int dy, bit l, bit m, bit r);
      mpush(hdr(l, m, r));
      mpush(sat8(dx));
      mpush(sat8(-dy));
      mpush(8'h00);
      mpush(8'h00);
   endtask

   task automatic send(int dx, int dy, bit l, bit m, bit r);
      evt_dx = DW'(dx); evt_dy = DW'(dy);
      btn_left = l; btn_mid = m; btn_right = r;
      evt_valid = 1'b1;
      @(negedge clk);
      evt_valid = 1'b0;
      repeat (5) @(negedge clk);
      model_pkt(dx, dy, l, m, r);
   endtask

   task automatic read_one(string req);
      logic [7:0] ed = (mc != 0) ? mq[mh] : 8'h00;
      chk(rd_avail === (mc != 0), "R8", int'(rd_avail), int'(mc != 0));
      chk(rd_data === ed, req, int'(rd_data), int'(ed));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      if (mc != 0) begin
         mh = (mh + 1) % QD;
         mc--;
      end
   endtask

   task automatic read_pkt();
      read_one("R1");
      read_one("R2");
      read_one("R3");
      read_one("R4");
      read_one("R4");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      process::self().srandom(32'd1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(rd_avail === 1'b0, "R10", int'(rd_avail), 0);
      chk(rd_data === 8'h00, "R10", int'(rd_data), 0);

      // R7 read while empty changes nothing
      read_one("R7");
      chk(rd_avail === 1'b0, "R7", int'(rd_avail), 0);

      // directed packets: buttons, clamp limits, negation
      send(5, 3, 0, 0, 0);        read_pkt();
      send(511, -512, 1, 1, 1);   read_pkt();
      send(-512, 511, 1, 0, 0);   read_pkt();
      send(-128, 128, 0, 1, 0);   read_pkt();
      send(127, -127, 0, 0, 1);   read_pkt();
      send(-127, 127, 1, 0, 1);   read_pkt();
      send(0, 0, 0, 0, 0);        read_pkt();
      chk(rd_avail === 1'b0, "R8", int'(rd_avail), 0);

      // R5 strobe held through packet writing, data changed: only first packet queued
      evt_dx = DW'(10); evt_dy = DW'(-20);
      btn_left = 1'b0; btn_mid = 1'b1; btn_right = 1'b1;
      evt_valid = 1'b1;
      @(negedge clk);
      evt_dx = DW'(-99); evt_dy = DW'(44); btn_left = 1'b1;
      repeat (5) @(negedge clk);
      evt_valid = 1'b0;
      @(negedge clk);
      model_pkt(10, -20, 0, 1, 1);
      chk(rd_avail === 1'b1, "R5", int'(rd_avail), 1);
      read_pkt();
      chk(rd_avail === 1'b0, "R5", int'(rd_avail), 0);

      // R9 clear
      send(1, 1, 0, 0, 0);
      send(2, 2, 0, 0, 0);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      mh = 0; mt = 0; mc = 0;
      chk(rd_avail === 1'b0, "R9", int'(rd_avail), 0);
      chk(rd_data === 8'h00, "R9", int'(rd_data), 0);
      send(-3, -4, 1, 0, 0);
      read_pkt();

      // R6/R11 offset pointers, overfill, drain across wrap
      send(7, 8, 0, 0, 0);
      repeat (3) read_one("R11");
      for (int k = 0; k < 53; k++)
         send($urandom_range(0, 1023) - 512, $urandom_range(0, 1023) - 512,
              1'($urandom), 1'($urandom), 1'($urandom));
      chk(mc == QD, "R6", mc, QD);
      while (mc != 0) read_one("R6");
      chk(rd_avail === 1'b0, "R6", int'(rd_avail), 0);

      // random mix
      for (int it = 0; it < 300; it++) begin
         if ($urandom_range(0, 2) == 0) begin
            int dx = ($urandom_range(0, 3) == 0) ? 511 : ($urandom_range(0, 1023) - 512);
            int dy = $urandom_range(0, 1023) - 512;
            send(dx, dy, 1'($urandom), 1'($urandom), 1'($urandom));
         end else begin
            int n = $urandom_range(1, 7);
            for (int j = 0; j < n; j++) read_one("R11");
         end
      end
      while (mc != 0) read_one("R11");
      read_one("R7");
      finish_run();
   end
endmodule